// File: doc/BRIEF.md
# Accumulator Processor with Register-Transfer Fetch

This block is a small processor with one accumulator. It runs a one-address instruction set. Every access to memory, for an instruction word or for an operand, passes through a memory address register and a memory data register, in a fixed sequence of register transfers. A program counter supplies fetch addresses. An instruction register holds the word being decoded. The arithmetic unit always combines the accumulator with an operand that was read from memory.

The processor drives a synchronous single-port RAM that lives outside the block. The RAM connects through an address, write data, read data and a write strobe, and it returns read data one clock after it samples the address. After reset the processor fetches from word 0 and runs until it decodes a halt. It then freezes and raises a halt flag, and the accumulator stays visible on an output port. A divide by a zero operand is caught and reported through a sticky flag.

Top module: `acc_cpu`

## Requirements
- R1: After reset, instructions execute in order from address 0. Each fetch reads the word at the program counter, and the program counter then advances by one.
- R2: An instruction word is 16 bits. Bits [15:12] hold the opcode and bits [11:0] hold the operand address. The codes are 0 no-op, 1 load, 2 store, 3 add, 4 subtract, 5 multiply, 6 divide and F halt. Any other code behaves as a no-op.
- R3: A load places the memory word at the operand address in the accumulator.
- R4: A store writes the accumulator to the operand address. The write lasts exactly one cycle, `mem_we` is never high on two consecutive cycles, and no other address is written.
- R5: Add and subtract combine the accumulator with the operand word modulo 2^16, and the result goes back into the accumulator.
- R6: Multiply leaves the low 16 bits of the unsigned product in the accumulator.
- R7: Divide leaves the truncated unsigned quotient in the accumulator. A zero divisor leaves the accumulator unchanged and sets `div_err`. `div_err` stays set until reset.
- R8: After a halt, `halted` rises and stays high, the accumulator holds its value, and no memory write occurs until reset.
- R9: From the start of an instruction's fetch, a no-op or unknown code takes 5 cycles, a store takes 6, and a load or arithmetic instruction takes 8. A halt raises `halted` 5 cycles after its fetch begins.
- R10: A synchronous active-high reset clears the accumulator, the program counter, `div_err`, `halted` and `mem_we`. Execution restarts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | RAM address, driven from the memory address register |
| mem_wdata | output | 16 | RAM write data, equal to the accumulator |
| mem_we | output | 1 | RAM write strobe |
| mem_rdata | input | 16 | RAM read data, valid one cycle after the address is sampled |
| halted | output | 1 | High once a halt has executed |
| acc_out | output | 16 | Accumulator value |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
Directed programs target specific corner cases:
- A subtract that goes below zero and then wraps back on the next add separates modulo arithmetic from saturating arithmetic.
- A multiply whose product overflows 16 bits shows which half of the product is kept.
- A chain of divides with a zero divisor in the middle, followed by an add, shows that the accumulator is preserved and that the error flag is sticky.
- A run of no-ops and undefined opcodes fixes the cycle count of the short path.

Random programs mix every opcode over a small data region that is seeded with zeros and small values. The final accumulator, the flag, the total cycle count and the memory image are each compared with an instruction-level model. This separates mistakes in sequencing, in operand fetch and in store addressing.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 4'h0,
    OP_LOAD  = 4'h1,
    OP_STORE = 4'h2,
    OP_ADD   = 4'h3,
    OP_SUB   = 4'h4,
    OP_MUL   = 4'h5,
    OP_DIV   = 4'h6,
    OP_HALT  = 4'hF
  } opcode_e;

  typedef enum logic [3:0] {
    ST_F_ADDR,
    ST_F_WAIT,
    ST_F_LATCH,
    ST_F_IR,
    ST_DECODE,
    ST_O_WAIT,
    ST_O_LATCH,
    ST_EXEC,
    ST_STORE,
    ST_HALT
  } state_e;

  function automatic logic needs_operand(input logic [OPC_W-1:0] code);
    return code == OP_LOAD || code == OP_ADD || code == OP_SUB ||
           code == OP_MUL  || code == OP_DIV;
  endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OPC_W-1:0]  op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] result,
  output logic              div_zero
);

  logic [DATA_W-1:0] sum, diff, prod, quot;

  assign sum  = acc + opnd;
  assign diff = acc - opnd;
  assign prod = acc * opnd;
  assign quot = (opnd == '0) ? acc : acc / opnd;

  always_comb begin
    div_zero = 1'b0;
    case (op)
      OP_LOAD: result = opnd;
      OP_ADD:  result = sum;
      OP_SUB:  result = diff;
      OP_MUL:  result = prod;
      OP_DIV: begin
        result   = quot;
        div_zero = (opnd == '0);
      end
      default: result = acc;
    endcase
  end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output state_e           state,
  output state_e           state_nx,
  output logic             ld_mar_pc,
  output logic             ld_mar_ir,
  output logic             ld_mdr,
  output logic             ld_ir,
  output logic             inc_pc,
  output logic             exec_en
);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_F_ADDR;
    else     state <= state_nx;
  end

  always_comb begin
    state_nx  = state;
    ld_mar_pc = 1'b0;
    ld_mar_ir = 1'b0;
    ld_mdr    = 1'b0;
    ld_ir     = 1'b0;
    inc_pc    = 1'b0;
    exec_en   = 1'b0;
    case (state)
      ST_F_ADDR: begin
        ld_mar_pc = 1'b1;
        state_nx  = ST_F_WAIT;
      end
      ST_F_WAIT:  state_nx = ST_F_LATCH;
      ST_F_LATCH: begin
        ld_mdr   = 1'b1;
        inc_pc   = 1'b1;
        state_nx = ST_F_IR;
      end
      ST_F_IR: begin
        ld_ir    = 1'b1;
        state_nx = ST_DECODE;
      end
      ST_DECODE: begin
        if (opcode == OP_HALT) begin
          state_nx = ST_HALT;
        end else if (opcode == OP_STORE) begin
          ld_mar_ir = 1'b1;
          state_nx  = ST_STORE;
        end else if (needs_operand(opcode)) begin
          ld_mar_ir = 1'b1;
          state_nx  = ST_O_WAIT;
        end else begin
          state_nx = ST_F_ADDR;
        end
      end
      ST_O_WAIT:  state_nx = ST_O_LATCH;
      ST_O_LATCH: begin
        ld_mdr   = 1'b1;
        state_nx = ST_EXEC;
      end
      ST_EXEC: begin
        exec_en  = 1'b1;
        state_nx = ST_F_ADDR;
      end
      ST_STORE: state_nx = ST_F_ADDR;
      ST_HALT:  state_nx = ST_HALT;
      default:  state_nx = ST_F_ADDR;
    endcase
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [DATA_W-1:0] acc_out,
  output logic              div_err
);

  localparam int OPC_LSB = DATA_W - OPC_W;

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, ir_q, acc_q;
  logic              err_q, we_q, halt_q;

  state_e            state, state_nx;
  logic              ld_mar_pc, ld_mar_ir, ld_mdr, ld_ir, inc_pc, exec_en;
  logic [OPC_W-1:0]  ir_op;
  logic [DATA_W-1:0] alu_res;
  logic              alu_dz;

  assign ir_op = ir_q[DATA_W-1:OPC_LSB];

  acc_cpu_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .opcode    (ir_op),
    .state     (state),
    .state_nx  (state_nx),
    .ld_mar_pc (ld_mar_pc),
    .ld_mar_ir (ld_mar_ir),
    .ld_mdr    (ld_mdr),
    .ld_ir     (ld_ir),
    .inc_pc    (inc_pc),
    .exec_en   (exec_en)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (ir_op),
    .acc      (acc_q),
    .opnd     (mdr_q),
    .result   (alu_res),
    .div_zero (alu_dz)
  );

  // Address path: PC and MAR
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
    end else begin
      if (inc_pc)         pc_q  <= pc_q + 1'b1;
      if (ld_mar_pc)      mar_q <= pc_q;
      else if (ld_mar_ir) mar_q <= ir_q[ADDR_W-1:0];
    end
  end

  // Data path: MDR and IR
  always_ff @(posedge clk) begin
    if (rst) begin
      mdr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (ld_mdr) mdr_q <= mem_rdata;
      if (ld_ir)  ir_q  <= mdr_q;
    end
  end

  // Accumulator and sticky error
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      err_q <= 1'b0;
    end else if (exec_en) begin
      if (alu_dz) err_q <= 1'b1;
      else        acc_q <= alu_res;
    end
  end

  // Registered strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      we_q   <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      we_q   <= (state_nx == ST_STORE);
      halt_q <= (state_nx == ST_HALT);
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = acc_q;
  assign mem_we    = we_q;
  assign halted    = halt_q;
  assign acc_out   = acc_q;
  assign div_err   = err_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_we,
  input logic              halted,
  input logic [DATA_W-1:0] acc_out,
  input logic              div_err
);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && !div_err && !halted && !mem_we));

  // R4
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    div_err |=> div_err);

  // R7
  dz_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(div_err) |-> acc_out == $past(acc_out));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(acc_out)));

  // R8
  halt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mem_we  (mem_we),
  .halted  (halted),
  .acc_out (acc_out),
  .div_err (div_err)
);

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;

  localparam int DW = 16;
  localparam int AW = 12;
  localparam int DBASE = 12'h200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_we, halted, div_err;
  logic [DW-1:0] acc_out;

  always #2 clk = ~clk;

  acc_cpu u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
    .acc_out(acc_out), .div_err(div_err)
  );

  // RAM model with loader port
  logic [DW-1:0] ram [0:(1<<AW)-1];
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  int            stray = 0;
  int            post_halt_wr = 0;

  always @(posedge clk) begin
    if (ld_en) ram[ld_addr] <= ld_data;
    else if (mem_we) begin
      ram[mem_addr] <= mem_wdata;
      if (mem_addr < DBASE || mem_addr >= DBASE + 16) stray = stray + 1;
      if (halted) post_halt_wr = post_halt_wr + 1;
    end
    mem_rdata <= ram[mem_addr];
  end

  int n_chk = 0, n_fail = 0;
  int tick = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    tick++;
    if (tick == 190000) begin
      chk(1'b0, "R9", "watchdog expired", tick, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  logic [DW-1:0] prog [0:31];
  logic [DW-1:0] dat  [0:15];
  logic [DW-1:0] mm   [0:(1<<AW)-1];
  logic [DW-1:0] exp_acc;
  bit            exp_err;
  int            exp_cyc;

  function automatic logic [DW-1:0] ins(input logic [3:0] op, input int a);
    return {op, 12'(a)};
  endfunction

  // Instruction-level reference model
  task automatic model_run();
    logic [AW-1:0] pc = '0;
    logic [DW-1:0] a  = '0;
    for (int i = 0; i < 32; i++) mm[i] = prog[i];
    for (int i = 0; i < 16; i++) mm[DBASE+i] = dat[i];
    exp_err = 0;
    exp_cyc = 0;
    for (int s = 0; s < 200; s++) begin
      logic [DW-1:0] w = mm[pc];
      logic [AW-1:0] ad = w[AW-1:0];
      pc = pc + 1'b1;
      case (w[15:12])
        4'h1: begin a = mm[ad]; exp_cyc += 8; end
        4'h2: begin mm[ad] = a; exp_cyc += 6; end
        4'h3: begin a = a + mm[ad]; exp_cyc += 8; end
        4'h4: begin a = a - mm[ad]; exp_cyc += 8; end
        4'h5: begin a = a * mm[ad]; exp_cyc += 8; end
        4'h6: begin
          if (mm[ad] == 0) exp_err = 1; else a = a / mm[ad];
          exp_cyc += 8;
        end
        4'hF: begin exp_cyc += 5; break; end
        default: exp_cyc += 5;
      endcase
    end
    exp_acc = a;
  endtask

  task automatic load_ram();
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      ld_en   = 1'b1;
      ld_addr = (i < 32) ? AW'(i) : AW'(DBASE + i - 32);
      ld_data = (i < 32) ? prog[i] : dat[i-32];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_prog(input string acc_req);
    int cyc = 0;
    int bad = 0;
    logic [DW-1:0] acc_snap;
    model_run();
    rst = 1'b1;
    load_ram();
    @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(acc_out == 0 && !div_err && !halted && !mem_we, "R10", "reset state",
        {acc_out, 4'(div_err), 4'(halted), 4'(mem_we)}, 0);
    stray = 0;
    post_halt_wr = 0;
    rst = 1'b0;
    while (!halted && cyc < 3000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    chk(acc_out == exp_acc, acc_req, "accumulator", acc_out, exp_acc);
    chk(div_err == exp_err, "R7", "div_err", div_err, exp_err);
    chk(cyc == exp_cyc, "R9", "cycles to halt", cyc, exp_cyc);
    for (int i = 0; i < 32; i++) if (ram[i] !== mm[i]) bad++;
    for (int i = 0; i < 16; i++) if (ram[DBASE+i] !== mm[DBASE+i]) bad++;
    // R4 memory image and no stray writes
    chk(bad == 0 && stray == 0, "R4", "memory mismatches+stray", bad + stray, 0);
    acc_snap = acc_out;
    repeat (8) @(negedge clk);
    // R8 frozen after halt
    chk(halted && acc_out == acc_snap && post_halt_wr == 0, "R8",
        "post-halt state", acc_out, acc_snap);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) prog[i] = ins(4'hF, 0);
    for (int i = 0; i < 16; i++) dat[i] = '0;
  endtask

  initial begin
    void'($urandom(32'd4242));

    // R3 R5: load, subtract wrapping below zero, add back
    clear_prog();
    dat[0] = 16'd5; dat[1] = 16'd7;
    prog[0] = ins(4'h1, DBASE); prog[1] = ins(4'h4, DBASE+1);
    prog[2] = ins(4'h3, DBASE); prog[3] = ins(4'hF, 0);
    run_prog("R5");
    chk(acc_out == 16'h0003, "R5", "wrap result", acc_out, 16'h0003);

    // R3 plain load
    clear_prog();
    dat[3] = 16'hBEEF;
    prog[0] = ins(4'h1, DBASE+3);
    run_prog("R3");
    chk(acc_out == 16'hBEEF, "R3", "load value", acc_out, 16'hBEEF);

    // R6 overflowing multiply
    clear_prog();
    dat[0] = 16'h1234; dat[1] = 16'h0100;
    prog[0] = ins(4'h1, DBASE); prog[1] = ins(4'h5, DBASE+1);
    run_prog("R6");
    chk(acc_out == 16'h3400, "R6", "low product", acc_out, 16'h3400);

    // R7 divide, divide by zero, then continue
    clear_prog();
    dat[0] = 16'd100; dat[1] = 16'd7; dat[2] = 16'd0;
    prog[0] = ins(4'h1, DBASE); prog[1] = ins(4'h6, DBASE+1);
    prog[2] = ins(4'h6, DBASE+2); prog[3] = ins(4'h3, DBASE+1);
    run_prog("R7");
    chk(acc_out == 16'd21 && div_err, "R7", "quotient then sticky err",
        {acc_out, 4'(div_err)}, {16'd21, 4'd1});

    // R10 reset clears the sticky flag
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(!div_err && acc_out == 0 && !halted, "R10", "reset after error",
        {acc_out, 4'(div_err)}, 0);

    // R4 two stores
    clear_prog();
    dat[0] = 16'h00AB;
    prog[0] = ins(4'h1, DBASE); prog[1] = ins(4'h2, DBASE+5);
    prog[2] = ins(4'h3, DBASE); prog[3] = ins(4'h2, DBASE+6);
    run_prog("R3");
    chk(ram[DBASE+5] == 16'h00AB && ram[DBASE+6] == 16'h0156, "R4",
        "stored words", ram[DBASE+6], 16'h0156);

    // R2 R9 no-op and undefined codes
    clear_prog();
    dat[0] = 16'h0042;
    prog[0] = ins(4'h0, 0); prog[1] = ins(4'h9, 12'h123);
    prog[2] = ins(4'h7, DBASE); prog[3] = ins(4'h1, DBASE);
    run_prog("R2");
    chk(exp_cyc == 28 && acc_out == 16'h0042, "R2", "unknown codes as no-op",
        acc_out, 16'h0042);

    // R1 random programs
    for (int p = 0; p < 60; p++) begin
      int len = 6 + int'($urandom % 18);
      clear_prog();
      for (int i = 0; i < 16; i++) begin
        int r = int'($urandom % 4);
        dat[i] = (r == 0) ? 16'd0 : (r == 1) ? DW'(1 + $urandom % 8) : DW'($urandom);
      end
      for (int i = 0; i < len; i++) begin
        int r = int'($urandom % 10);
        int ad = DBASE + int'($urandom % 16);
        case (r)
          0: prog[i] = ins(4'h0, ad);
          1, 8: prog[i] = ins(4'h1, ad);
          2: prog[i] = ins(4'h2, ad);
          3: prog[i] = ins(4'h3, ad);
          4: prog[i] = ins(4'h4, ad);
          5: prog[i] = ins(4'h5, ad);
          6, 7: prog[i] = ins(4'h6, ad);
          default: prog[i] = ins(4'(8 + $urandom % 7), ad);
        endcase
      end
      run_prog("R1");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule